// File: doc/BRIEF.md
# Match-Capture Timer/Counter

This block is a 32-bit counting peripheral with a prescaler in front of it. The count either advances on clock cycles or follows edges seen on an external count pin. The prescaler divides whichever source is selected. Four match comparators watch the count. When one of them hits, it can flag an interrupt, send the count back to zero, or freeze counting. Each comparator also drives its own output pin, which can go low, go high, toggle or stay as it is.

Two capture channels each watch a pin through a two-flop synchronizer. On a chosen edge they record the current count, and they can raise an interrupt when they do.

Software works the block through a small register port. A write takes one cycle and read data is combinational, so there is no back-pressure and no stream interface. The interrupt line is a level. It stays high while any flag is set, and software clears flags by writing 1 to them.

Top module: `mct_timer`

## Requirements
- R1: After `rst_n` is low, the count, the prescale count, every configuration register, both capture registers, all match outputs, the flags and `irq` all read zero.
- R2: In timer mode with enable set, the prescale count steps 0,1,...,P, where P is the prescale register at address 2. When it has reached P, the next enabled cycle returns it to 0 and advances the count by one. So after k enabled cycles from zero, the count is k/(P+1) and the prescale count is k mod (P+1).
- R3: Control register (address 0) bit 0 is enable and bit 1 is a synchronous clear. While bit 1 is set, the count and the prescale count are 0 one cycle later and stay 0.
- R4: Mode register (address 1) bits [1:0] choose the step source: 0 clock cycles, 1 rising edges, 2 falling edges, 3 both edges of `cnt_in`. `cnt_in` passes through two synchronizing flops, and the prescaler divides the edge events.
- R5: A match on channel i happens on a step where the prescale count has reached P and the count equals match register i (addresses 10 to 13). If the reset option of channel i is set (match configuration at address 5, bit 3i+1), the count goes to 0 instead of advancing.
- R6: If the stop option of a matching channel is set (address 5, bit 3i+2), the count and the prescale count hold on that step and the enable bit clears. Stop wins over reset and over a write to the control register in the same cycle.
- R7: On its match, output i follows the 2-bit action in address 7, bits [2i+1:2i]: 00 hold, 01 low, 10 high, 11 toggle. A write to address 8 loads all output levels from bits [3:0]. A match on a channel wins over that write for that channel.
- R8: Capture channel j has three bits in address 6: 3j enables rising edges, 3j+1 enables falling edges, 3j+2 enables the interrupt. On an enabled edge of the synchronized `cap_in[j]`, register 14+j loads the count. With the pin changed before edge E, the register holds the count of the cycle after E+1. Edges that are not enabled leave it unchanged.
- R9: The flags register (address 9) has bits [3:0] for match channels with their interrupt bit (address 5, bit 3i) set, and bits [5:4] for capture channels. Writing 1 to a bit clears it, and a new event in the same cycle wins. `irq` is high exactly while any flag is set.
- R10: Address 3 reads the prescale count and address 4 reads the count. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| cnt_in | input | 1 | External count pin (asynchronous) |
| cap_in | input | 2 | Capture pins (asynchronous) |
| match_out | output | 4 | Match output pins |
| irq | output | 1 | Level interrupt |

## Verification
Some properties are checked on every cycle. The count only ever steps by one or returns to zero, and it advances only after the prescale count has reached its limit. The synchronous clear zeroes both counters. A stop freezes the count and drops enable. Outputs and capture registers change only on their own events. Clearing every flag with no new event lowers `irq`. The bench scenarios cover the rest: the arithmetic of count and prescale against random limits, the edge-source modes, the synchronizer latency of capture, the output action encodings over many match periods, and the masking of interrupts.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] AD_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] AD_MODE  = 4'd1;
  localparam logic [REG_AW-1:0] AD_PRESC = 4'd2;
  localparam logic [REG_AW-1:0] AD_PCNT  = 4'd3;
  localparam logic [REG_AW-1:0] AD_TCNT  = 4'd4;
  localparam logic [REG_AW-1:0] AD_MCFG  = 4'd5;
  localparam logic [REG_AW-1:0] AD_CCFG  = 4'd6;
  localparam logic [REG_AW-1:0] AD_OACT  = 4'd7;
  localparam logic [REG_AW-1:0] AD_OLVL  = 4'd8;
  localparam logic [REG_AW-1:0] AD_FLAGS = 4'd9;
  localparam logic [REG_AW-1:0] AD_MAT0  = 4'd10;
  localparam logic [REG_AW-1:0] AD_CAP0  = 4'd14;

  typedef enum logic [1:0] {
    SRC_CLOCK = 2'd0,
    SRC_RISE  = 2'd1,
    SRC_FALL  = 2'd2,
    SRC_BOTH  = 2'd3
  } step_src_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } out_act_e;
endpackage

// File: rtl/mct_edge_sync.sv
module mct_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], pin};
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/mct_count_core.sv
module mct_count_core #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          sclear,
  input  logic          step,
  input  logic [CW-1:0] limit,
  input  logic          zero_req,
  input  logic          stop_req,
  output logic          term,
  output logic [CW-1:0] pcount,
  output logic [CW-1:0] count
);
  logic tick;

  assign tick = enable & ~sclear & step;
  assign term = tick & (pcount >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcount <= '0;
      count  <= '0;
    end else if (sclear) begin
      pcount <= '0;
      count  <= '0;
    end else if (tick && !stop_req) begin
      if (term) begin
        pcount <= '0;
        count  <= zero_req ? '0 : count + 1'b1;
      end else begin
        pcount <= pcount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mct_capture.sv
module mct_capture #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          rise_en,
  input  logic          fall_en,
  input  logic [CW-1:0] count,
  output logic          load,
  output logic [CW-1:0] snap
);
  logic rise, fall;

  mct_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin), .rise(rise), .fall(fall)
  );

  assign load = (rise & rise_en) | (fall & fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap <= '0;
    else if (load) snap <= count;
  end
endmodule

// File: rtl/mct_match_out.sv
module mct_match_out (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  mct_pkg::out_act_e act,
  input  logic             lvl_wr,
  input  logic             lvl_d,
  output logic             q
);
  import mct_pkg::*;
  logic nxt;

  always_comb begin
    nxt = q;
    if (hit) begin
      unique case (act)
        ACT_HOLD:   nxt = q;
        ACT_LOW:    nxt = 1'b0;
        ACT_HIGH:   nxt = 1'b1;
        ACT_TOGGLE: nxt = ~q;
      endcase
    end else if (lvl_wr) begin
      nxt = lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int unsigned CW     = 32,
  parameter int unsigned N_MAT  = 4,
  parameter int unsigned N_CAP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             cnt_in,
  input  logic [N_CAP-1:0] cap_in,
  output logic [N_MAT-1:0] match_out,
  output logic             irq
);
  localparam int unsigned MCFG_W = 3 * N_MAT;
  localparam int unsigned CCFG_W = 3 * N_CAP;
  localparam int unsigned OACT_W = 2 * N_MAT;
  localparam int unsigned FLAG_W = N_MAT + N_CAP;

  logic              en_q, sclr_q;
  step_src_e         src_q;
  logic [CW-1:0]     limit_q;
  logic [MCFG_W-1:0] mcfg_q;
  logic [CCFG_W-1:0] ccfg_q;
  logic [OACT_W-1:0] oact_q;
  logic [FLAG_W-1:0] flags_q;
  logic [CW-1:0]     mr_q [N_MAT];

  logic [CW-1:0]     pcount, count;
  logic              term, step, zero_req, stop_req;
  logic              cnt_rise, cnt_fall;
  logic [N_MAT-1:0]  match_evt, rst_mask, stop_mask, mint_mask;
  logic [N_CAP-1:0]  cap_load, cap_int;
  logic [CW-1:0]     cap_val [N_CAP];
  logic [N_CAP*CW-1:0] cap_bus;
  logic [FLAG_W-1:0] set_evt, clr_mask;
  logic              wr_ctrl, wr_olvl, wr_flags;

  assign wr_ctrl  = reg_wr && (reg_addr == AD_CTRL);
  assign wr_olvl  = reg_wr && (reg_addr == AD_OLVL);
  assign wr_flags = reg_wr && (reg_addr == AD_FLAGS);

  // step source selection
  mct_edge_sync #(.STAGES(2)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin(cnt_in), .rise(cnt_rise), .fall(cnt_fall)
  );

  always_comb begin
    unique case (src_q)
      SRC_CLOCK: step = 1'b1;
      SRC_RISE:  step = cnt_rise;
      SRC_FALL:  step = cnt_fall;
      SRC_BOTH:  step = cnt_rise | cnt_fall;
    endcase
  end

  mct_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(en_q), .sclear(sclr_q), .step(step),
    .limit(limit_q), .zero_req(zero_req), .stop_req(stop_req),
    .term(term), .pcount(pcount), .count(count)
  );

  // match channels
  for (genvar i = 0; i < N_MAT; i++) begin : g_mat
    assign match_evt[i] = term && (count == mr_q[i]);
    assign mint_mask[i] = mcfg_q[3*i];
    assign rst_mask[i]  = mcfg_q[3*i+1];
    assign stop_mask[i] = mcfg_q[3*i+2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mr_q[i] <= '0;
      else if (reg_wr && (reg_addr == AD_MAT0 + 4'(i))) mr_q[i] <= reg_wdata[CW-1:0];
    end

    mct_match_out u_out (
      .clk(clk), .rst_n(rst_n), .hit(match_evt[i]),
      .act(out_act_e'(oact_q[2*i +: 2])), .lvl_wr(wr_olvl),
      .lvl_d(reg_wdata[i]), .q(match_out[i])
    );
  end

  assign zero_req = |(match_evt & rst_mask);
  assign stop_req = |(match_evt & stop_mask);

  // capture channels
  for (genvar j = 0; j < N_CAP; j++) begin : g_cap
    assign cap_int[j] = ccfg_q[3*j+2];
    mct_capture #(.CW(CW)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_in[j]),
      .rise_en(ccfg_q[3*j]), .fall_en(ccfg_q[3*j+1]),
      .count(count), .load(cap_load[j]), .snap(cap_val[j])
    );
    assign cap_bus[j*CW +: CW] = cap_val[j];
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sclr_q  <= 1'b0;
      src_q   <= SRC_CLOCK;
      limit_q <= '0;
      mcfg_q  <= '0;
      ccfg_q  <= '0;
      oact_q  <= '0;
    end else begin
      if (stop_req)     en_q <= 1'b0;
      else if (wr_ctrl) en_q <= reg_wdata[0];
      if (wr_ctrl) sclr_q <= reg_wdata[1];
      if (reg_wr) begin
        unique case (reg_addr)
          AD_MODE:  src_q   <= step_src_e'(reg_wdata[1:0]);
          AD_PRESC: limit_q <= reg_wdata[CW-1:0];
          AD_MCFG:  mcfg_q  <= reg_wdata[MCFG_W-1:0];
          AD_CCFG:  ccfg_q  <= reg_wdata[CCFG_W-1:0];
          AD_OACT:  oact_q  <= reg_wdata[OACT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // interrupt flags
  assign set_evt  = {cap_load & cap_int, match_evt & mint_mask};
  assign clr_mask = wr_flags ? reg_wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_mask) | set_evt;
  end

  assign irq = |flags_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      AD_CTRL:  reg_rdata[1:0]        = {sclr_q, en_q};
      AD_MODE:  reg_rdata[1:0]        = src_q;
      AD_PRESC: reg_rdata[CW-1:0]     = limit_q;
      AD_PCNT:  reg_rdata[CW-1:0]     = pcount;
      AD_TCNT:  reg_rdata[CW-1:0]     = count;
      AD_MCFG:  reg_rdata[MCFG_W-1:0] = mcfg_q;
      AD_CCFG:  reg_rdata[CCFG_W-1:0] = ccfg_q;
      AD_OACT:  reg_rdata[OACT_W-1:0] = oact_q;
      AD_OLVL:  reg_rdata[N_MAT-1:0]  = match_out;
      AD_FLAGS: reg_rdata[FLAG_W-1:0] = flags_q;
      4'd10:    reg_rdata[CW-1:0]     = mr_q[0];
      4'd11:    reg_rdata[CW-1:0]     = mr_q[1];
      4'd12:    reg_rdata[CW-1:0]     = mr_q[2];
      4'd13:    reg_rdata[CW-1:0]     = mr_q[3];
      4'd14:    reg_rdata[CW-1:0]     = cap_val[0];
      4'd15:    reg_rdata[CW-1:0]     = cap_val[1];
      default: ;
    endcase
  end
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
  parameter int unsigned CW    = 32,
  parameter int unsigned N_MAT = 4,
  parameter int unsigned N_CAP = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CW-1:0]       count,
  input logic [CW-1:0]       pcount,
  input logic [CW-1:0]       limit_q,
  input logic                sclr_q,
  input logic                en_q,
  input logic                stop_req,
  input logic [N_MAT-1:0]    match_evt,
  input logic [N_CAP-1:0]    cap_load,
  input logic [N_CAP*CW-1:0] cap_bus,
  input logic [N_MAT-1:0]    match_out,
  input logic                reg_wr,
  input logic [3:0]          reg_addr,
  input logic [31:0]         reg_wdata,
  input logic [N_MAT+N_CAP-1:0] set_evt,
  input logic                irq
);
  localparam int unsigned FLAG_W = N_MAT + N_CAP;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0));

  assert_advance_after_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count) + 1'b1) |-> ($past(pcount) >= $past(limit_q)));

  assert_sclear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclr_q |=> (count == '0 && pcount == '0));

  assert_stop_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!en_q && $stable(count) && $stable(pcount)));

  for (genvar i = 0; i < N_MAT; i++) begin : g_mo
    assert_out_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!match_evt[i] && !(reg_wr && reg_addr == 4'd8)) |=> $stable(match_out[i]));
  end

  for (genvar j = 0; j < N_CAP; j++) begin : g_cp
    assert_cap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_load[j] |=> $stable(cap_bus[j*CW +: CW]));
  end

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd9 && (&reg_wdata[FLAG_W-1:0]) && set_evt == '0) |=> !irq);
endmodule

bind mct_timer mct_timer_chk #(.CW(CW), .N_MAT(N_MAT), .N_CAP(N_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .pcount(pcount), .limit_q(limit_q),
  .sclr_q(sclr_q), .en_q(en_q), .stop_req(stop_req), .match_evt(match_evt),
  .cap_load(cap_load), .cap_bus(cap_bus), .match_out(match_out),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .set_evt(set_evt), .irq(irq)
);

// File: tb/mct_timer_bench.sv
`timescale 1ns/1ps
module mct_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cnt_in = 1'b0;
  logic [1:0]  cap_in = '0;
  logic [3:0]  match_out;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mct_timer u_mct_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_in(cnt_in),
    .cap_in(cap_in), .match_out(match_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.4;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnt_in = 1'b0; cap_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_cnt(input int n);
    for (int p = 0; p < n; p++) begin
      cnt_in = 1'b1; repeat (4) @(negedge clk);
      cnt_in = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] div_cnt(input int k, input int p);
    return 32'(k / (p + 1));
  endfunction

  initial begin : watchdog
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, v2;
    int p, k, m;
    void'($urandom(32'd90210));

    // R1 reset state
    do_reset();
    rd(4'd4, v); chk("R1 count", v, 0);
    rd(4'd3, v); chk("R1 pcount", v, 0);
    rd(4'd0, v); chk("R1 ctrl", v, 0);
    rd(4'd14, v); chk("R1 cap0", v, 0);
    chk("R1 outputs", {28'd0, match_out}, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 random prescale in timer mode
    for (int it = 0; it < 5; it++) begin
      do_reset();
      p = $urandom % 6;
      k = 1 + $urandom % 40;
      wr(4'd2, p);
      wr(4'd0, 32'd1);
      run(k);
      rd(4'd4, v);  chk("R2 count", v, div_cnt(k, p));
      rd(4'd3, v2); chk("R2 pcount", v2, 32'(k % (p + 1)));
    end
    rd(4'd5, v); chk("R10 unused-bits mcfg", v, 0);

    // R3 synchronous clear
    do_reset();
    wr(4'd0, 32'd1);
    run(7);
    wr(4'd0, 32'd3);
    run(5);
    rd(4'd4, v); chk("R3 count held", v, 0);
    rd(4'd3, v); chk("R3 pcount held", v, 0);

    // R5 + R9 match reset with interrupt, random period
    for (int it = 0; it < 3; it++) begin
      do_reset();
      m = 2 + $urandom % 6;
      k = m + 2 + $urandom % 30;
      wr(4'd10, m);
      wr(4'd5, 32'h3);
      wr(4'd0, 32'd1);
      run(k);
      rd(4'd4, v); chk("R5 wrap count", v, 32'(k % (m + 1)));
      rd(4'd9, v); chk("R9 match flag", v, 32'h1);
      chk("R9 irq high", {31'd0, irq}, 1);
      wr(4'd5, 32'h2);
      wr(4'd9, 32'h1);
      rd(4'd9, v); chk("R9 flag cleared", v, 0);
      chk("R9 irq low", {31'd0, irq}, 0);
    end

    // R6 stop on match channel 1
    do_reset();
    wr(4'd2, 32'd1);
    wr(4'd11, 32'd5);
    wr(4'd5, 32'h20);
    wr(4'd0, 32'd1);
    run(40);
    rd(4'd4, v); chk("R6 count frozen", v, 5);
    rd(4'd3, v); chk("R6 pcount frozen", v, 1);
    rd(4'd0, v); chk("R6 enable cleared", v, 0);
    rd(4'd9, v); chk("R9 no flag without int enable", v, 0);

    // R7 output actions: ch0 low@1, ch1 hold, ch2 toggle@3 with reset, ch3 high@2
    for (int it = 0; it < 3; it++) begin
      do_reset();
      k = 10 + $urandom % 50;
      wr(4'd8, 32'h3);
      wr(4'd10, 32'd1);
      wr(4'd11, 32'd0);
      wr(4'd12, 32'd3);
      wr(4'd13, 32'd2);
      wr(4'd5, 32'h080);
      wr(4'd7, {24'd0, 2'b10, 2'b11, 2'b00, 2'b01});
      wr(4'd0, 32'd1);
      run(k);
      chk("R7 low action", {31'd0, match_out[0]}, 0);
      chk("R7 hold action", {31'd0, match_out[1]}, 1);
      chk("R7 toggle action", {31'd0, match_out[2]}, 32'((k / 4) & 1));
      chk("R7 high action", {31'd0, match_out[3]}, 1);
      rd(4'd4, v); chk("R5 period four", v, 32'(k % 4));
    end

    // R4 counter modes
    for (int md = 1; md < 4; md++) begin
      do_reset();
      k = 2 + $urandom % 5;
      wr(4'd1, md);
      wr(4'd0, 32'd1);
      pulse_cnt(k);
      rd(4'd4, v);
      chk("R4 edge count", v, (md == 3) ? 32'(2 * k) : 32'(k));
    end
    do_reset();
    wr(4'd1, 32'd1);
    wr(4'd2, 32'd1);
    wr(4'd0, 32'd1);
    pulse_cnt(5);
    rd(4'd4, v); chk("R4 prescaled edges", v, 2);

    // R8 capture timing and edge selection, R9 capture flag
    do_reset();
    wr(4'd6, 32'h15);
    wr(4'd0, 32'd1);
    k = 5 + $urandom % 20;
    run(k);
    cap_in = 2'b11;
    run(3);
    rd(4'd14, v); chk("R8 rise capture", v, 32'(k + 2));
    rd(4'd15, v); chk("R8 rise ignored on fall-only", v, 0);
    cap_in[1] = 1'b0;
    run(3);
    rd(4'd15, v); chk("R8 fall capture", v, 32'(k + 5));
    rd(4'd9, v); chk("R9 capture flag", v, 32'h10);
    wr(4'd9, 32'h10);
    chk("R9 capture flag cleared irq", {31'd0, irq}, 0);
    rd(4'd14, v); chk("R8 cap0 unchanged", v, 32'(k + 2));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule